// File: doc/BRIEF.md
# Board Control Register File with Interrupt Aggregation

This block is the register slave of a board-management logic device. A host reaches it over a plain 16-bit register bus made of a byte address, write data, read data and single-cycle read and write strobes. Every register is one 16-bit word at an even byte offset. A read strobe loads the addressed word into a read-data register, which keeps that value until the next read.

Thirty-two level-sensitive interrupt sources are resynchronised and shown in two 16-bit status words. Two matching mask words hold one bit per source, and a set mask bit blocks its source. Whenever an unmasked source is high, the block drives a single active-low level interrupt to the host. Source 15 belongs to the on-board Ethernet controller.

The remaining registers are control and readback words:
- two device-reset control words; bit 2 of the first one holds the Ethernet device in reset;
- a backlight enable bit;
- a word that packs the CPU-board and base-board revision codes;
- four words that read back the DIP switch banks;
- a word that reports three clock-mode strap pins.

Top module: `board_ctrl_regs`

## Requirements
- R1: While reset is asserted and right after it: both mask words read 0xFFFF, irq_n is 1, the backlight output and both reset words are 0, and bus_rdata is 0x0000.
- R2: Status word 0x0020 holds sources 15..0 and status word 0x0022 holds sources 31..16, with bit n = source n. Each status bit follows its source level two clock edges after the source changes.
- R3: The mask words at 0x0030 (sources 15..0) and 0x0032 (sources 31..16) can be written and read back. A mask bit of 1 blocks its source, and a mask bit of 0 lets it through.
- R4: irq_n is 0 in the cycle after any status bit is 1 while its mask bit is 0. Otherwise irq_n is 1 in that cycle.
- R5: The reset words at 0x10D0 and 0x10D2 can be written and read back. Each one drives its output port, dev_rst_a or dev_rst_b, bit for bit. dev_rst_a bit 2 is the Ethernet reset.
- R6: Word 0x1100 reads {cpu_rev, base_rev}, with the CPU-board code in bits 15:8. Writes to this word have no effect.
- R7: Bit 0 of word 0x10B4 is the backlight enable (1 = on). It drives backlight_on. The other bits of this word read as 0.
- R8: Word 0x10E0 returns clk_mode_strap[2:0] in bits 10:8, and every other bit reads 0.
- R9: Words 0x0070, 0x0072, 0x0074 and 0x0076 return switch banks 0 to 3, and bank k is sw_level[16k+15:16k]. A switch in the ON position drives 0. Writes to these words have no effect.
- R10: Odd or unmapped addresses read 0x0000. A write to such an address changes no register.
- R11: bus_rdata is loaded on the clock edge where bus_rd is 1, and it keeps its value while bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 16 | Registered read data |
| src_lvl | input | 32 | Asynchronous interrupt source levels |
| cpu_rev | input | 8 | CPU-board revision code |
| base_rev | input | 8 | Base-board revision code |
| sw_level | input | 64 | DIP switch levels, four banks of 16 |
| clk_mode_strap | input | 3 | Clock-mode strap pins |
| irq_n | output | 1 | Combined level interrupt, active low |
| dev_rst_a | output | 16 | Device reset controls, first word |
| dev_rst_b | output | 16 | Device reset controls, second word |
| backlight_on | output | 1 | Backlight enable |

## Verification
The assertions check the following on every cycle:
- the two-edge latency from a source to its status bit;
- the one-cycle link from a pending, unmasked source to irq_n, in both directions;
- mask and backlight write capture;
- reset-word stability when no write targets it;
- the revision, strap and unmapped read values;
- hold of bus_rdata between reads.

Only the bench scenarios can show that the fixed map is right as a whole:
- that the Ethernet source sits in bit 15 of the lower status word;
- that the switch banks appear in order;
- that writes to read-only or odd addresses leave the writable words untouched;
- that every source starts blocked after reset.

// File: rtl/brd_pkg.sv
`timescale 1ns/1ps
package brd_pkg;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 16;
    localparam int SRC_HALVES = 2;
    localparam int N_SRC      = REG_W * SRC_HALVES;
    localparam int REV_W      = REG_W / 2;
    localparam int N_STRAP    = 3;
    localparam int STRAP_LSB  = 8;
    localparam int OFF_STEP   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [REG_W-1:0]  word_t;

    localparam addr_t OFF_STAT  = 16'h0020;
    localparam addr_t OFF_MASK  = 16'h0030;
    localparam addr_t OFF_SW    = 16'h0070;
    localparam addr_t OFF_LAMP  = 16'h10B4;
    localparam addr_t OFF_RST_A = 16'h10D0;
    localparam addr_t OFF_RST_B = 16'h10D2;
    localparam addr_t OFF_MODE  = 16'h10E0;
    localparam addr_t OFF_VER   = 16'h1100;

    function automatic addr_t slot(input addr_t base, input int idx);
        return base + addr_t'(idx * OFF_STEP);
    endfunction
endpackage

// File: rtl/brd_sync.sv
`timescale 1ns/1ps
module brd_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] held;
        logic [1:0]   age;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.held = st_q.meta;
        if (st_q.age != 2'd3) begin
            st_d.age = st_q.age + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.held;

    // R2: a status bit shows the source level from two edges earlier
    assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age >= 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/brd_irq_unit.sv
`timescale 1ns/1ps
module brd_irq_unit
    import brd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      stat,
    input  logic [SRC_HALVES-1:0] mask_wr,
    input  word_t                 wdata,
    output logic [N_SRC-1:0]      mask,
    output logic                  irq_n
);
    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic             irq_n;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < SRC_HALVES; h++) begin
            if (mask_wr[h]) begin
                st_d.mask[h*REG_W +: REG_W] = wdata;
            end
        end
        st_d.irq_n = ~|(stat & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask  = st_q.mask;
    assign irq_n = st_q.irq_n;

    // R4: an unmasked active source pulls the line low on the next cycle
    assert_irq_assert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & ~mask)) |=> !irq_n);
    // R4: with no unmasked source active the line is released
    assert_irq_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & ~mask)) |=> irq_n);

    for (genvar g = 0; g < SRC_HALVES; g++) begin : g_mask_chk
        // R3: a write to a mask word is captured in full
        assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            mask_wr[g] |=> (mask[g*REG_W +: REG_W] == $past(wdata)));
        // R3: a mask word keeps its value when no write targets it
        assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_wr[g] |=> $stable(mask[g*REG_W +: REG_W]));
    end
endmodule

// File: rtl/brd_ctrl_regs.sv
`timescale 1ns/1ps
module brd_ctrl_regs
    import brd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_rst_a,
    input  logic  wr_rst_b,
    input  logic  wr_lamp,
    input  word_t wdata,
    output word_t rst_a,
    output word_t rst_b,
    output logic  lamp
);
    typedef struct packed {
        word_t rst_a;
        word_t rst_b;
        logic  lamp;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_rst_a) st_d.rst_a = wdata;
        if (wr_rst_b) st_d.rst_b = wdata;
        if (wr_lamp)  st_d.lamp  = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_a = st_q.rst_a;
    assign rst_b = st_q.rst_b;
    assign lamp  = st_q.lamp;

    // R7: the backlight bit takes bit 0 of the written word
    assert_lamp_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lamp |=> (lamp == $past(wdata[0])));
    // R5: reset words change only when written
    assert_rst_a_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rst_a |=> $stable(rst_a));
    assert_rst_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rst_b |=> $stable(rst_b));
endmodule

// File: rtl/board_ctrl_regs.sv
`timescale 1ns/1ps
module board_ctrl_regs
    import brd_pkg::*;
#(
    parameter int N_SW_BANKS = 4,
    localparam int SW_W      = N_SW_BANKS * REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [N_SRC-1:0]   src_lvl,
    input  logic [REV_W-1:0]   cpu_rev,
    input  logic [REV_W-1:0]   base_rev,
    input  logic [SW_W-1:0]    sw_level,
    input  logic [N_STRAP-1:0] clk_mode_strap,
    output logic               irq_n,
    output logic [REG_W-1:0]   dev_rst_a,
    output logic [REG_W-1:0]   dev_rst_b,
    output logic               backlight_on
);
    logic [N_SRC-1:0]      stat;
    logic [N_SRC-1:0]      mask;
    logic [SRC_HALVES-1:0] mask_wr;
    logic                  wr_rst_a, wr_rst_b, wr_lamp;
    word_t                 rd_val;
    logic                  rd_hit;

    typedef struct packed {
        word_t rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    brd_sync #(.W(N_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_lvl),
        .sync_out (stat)
    );

    brd_irq_unit u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat    (stat),
        .mask_wr (mask_wr),
        .wdata   (bus_wdata),
        .mask    (mask),
        .irq_n   (irq_n)
    );

    brd_ctrl_regs u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_rst_a (wr_rst_a),
        .wr_rst_b (wr_rst_b),
        .wr_lamp  (wr_lamp),
        .wdata    (bus_wdata),
        .rst_a    (dev_rst_a),
        .rst_b    (dev_rst_b),
        .lamp     (backlight_on)
    );

    // Write decode: only the mask, reset and backlight words accept data
    always_comb begin
        for (int h = 0; h < SRC_HALVES; h++) begin
            mask_wr[h] = bus_wr && (bus_addr == slot(OFF_MASK, h));
        end
        wr_rst_a = bus_wr && (bus_addr == OFF_RST_A);
        wr_rst_b = bus_wr && (bus_addr == OFF_RST_B);
        wr_lamp  = bus_wr && (bus_addr == OFF_LAMP);
    end

    // Read decode: every word at its fixed offset, anything else is zero
    always_comb begin
        rd_val = '0;
        rd_hit = 1'b0;
        for (int h = 0; h < SRC_HALVES; h++) begin
            if (bus_addr == slot(OFF_STAT, h)) begin
                rd_val = stat[h*REG_W +: REG_W];
                rd_hit = 1'b1;
            end
            if (bus_addr == slot(OFF_MASK, h)) begin
                rd_val = mask[h*REG_W +: REG_W];
                rd_hit = 1'b1;
            end
        end
        for (int b = 0; b < N_SW_BANKS; b++) begin
            if (bus_addr == slot(OFF_SW, b)) begin
                rd_val = sw_level[b*REG_W +: REG_W];
                rd_hit = 1'b1;
            end
        end
        if (bus_addr == OFF_LAMP) begin
            rd_val[0] = backlight_on;
            rd_hit    = 1'b1;
        end
        if (bus_addr == OFF_RST_A) begin
            rd_val = dev_rst_a;
            rd_hit = 1'b1;
        end
        if (bus_addr == OFF_RST_B) begin
            rd_val = dev_rst_b;
            rd_hit = 1'b1;
        end
        if (bus_addr == OFF_MODE) begin
            rd_val[STRAP_LSB +: N_STRAP] = clk_mode_strap;
            rd_hit = 1'b1;
        end
        if (bus_addr == OFF_VER) begin
            rd_val = {cpu_rev, base_rev};
            rd_hit = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    // R6: revision word packs both codes, CPU board on top
    assert_version_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_VER) |=> (bus_rdata == {$past(cpu_rev), $past(base_rev)}));
    // R8: strap pins land in their field and nothing else is set
    assert_strap_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_MODE) |=>
        ((bus_rdata[STRAP_LSB +: N_STRAP] == $past(clk_mode_strap)) &&
         ($countones(bus_rdata) == $countones($past(clk_mode_strap)))));
    // R10: reads of unmapped or odd addresses return zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0));
    // R11: read data holds between read strobes
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/board_ctrl_regs_tb.sv
`timescale 1ns/1ps
module board_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [31:0] src_lvl = '0;
    logic [7:0]  cpu_rev = 8'h3A;
    logic [7:0]  base_rev = 8'hC5;
    logic [63:0] sw_level = 64'hFFFF_0F0F_00FF_F00F;
    logic [2:0]  clk_mode_strap = 3'b101;
    logic        irq_n;
    logic [15:0] dev_rst_a, dev_rst_b;
    logic        backlight_on;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    board_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
        .cpu_rev(cpu_rev), .base_rev(base_rev), .sw_level(sw_level),
        .clk_mode_strap(clk_mode_strap), .irq_n(irq_n), .dev_rst_a(dev_rst_a),
        .dev_rst_b(dev_rst_b), .backlight_on(backlight_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_pipe, m_stat, m_mask;
    logic        m_irq_n, m_lamp, m_live = 1'b0;
    logic [15:0] m_rdata, m_ra, m_rb;
    string       m_tag = "R1";

    function automatic logic [15:0] m_look(input logic [15:0] a);
        case (a)
            16'h0020: return m_stat[15:0];
            16'h0022: return m_stat[31:16];
            16'h0030: return m_mask[15:0];
            16'h0032: return m_mask[31:16];
            16'h0070: return sw_level[15:0];
            16'h0072: return sw_level[31:16];
            16'h0074: return sw_level[47:32];
            16'h0076: return sw_level[63:48];
            16'h10B4: return {15'd0, m_lamp};
            16'h10D0: return m_ra;
            16'h10D2: return m_rb;
            16'h10E0: return {5'd0, clk_mode_strap, 8'd0};
            16'h1100: return {cpu_rev, base_rev};
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic string m_tag_of(input logic [15:0] a);
        case (a)
            16'h0020, 16'h0022: return "R2";
            16'h0030, 16'h0032: return "R3";
            16'h0070, 16'h0072, 16'h0074, 16'h0076: return "R9";
            16'h10B4: return "R7";
            16'h10D0, 16'h10D2: return "R5";
            16'h10E0: return "R8";
            16'h1100: return "R6";
            default:  return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        logic [15:0] nrd;
        logic        nirq;
        string       ntag;
        if (!rst_n) begin
            m_pipe = '0; m_stat = '0; m_mask = '1; m_irq_n = 1'b1;
            m_rdata = '0; m_ra = '0; m_rb = '0; m_lamp = 1'b0;
            m_tag = "R1"; m_live = 1'b1;
        end else begin
            nrd  = m_rdata;
            ntag = "R11";
            if (bus_rd) begin
                nrd  = m_look(bus_addr);
                ntag = m_tag_of(bus_addr);
            end
            nirq = ((m_stat & ~m_mask) == 32'd0);
            if (bus_wr) begin
                case (bus_addr)
                    16'h0030: m_mask[15:0]  = bus_wdata;
                    16'h0032: m_mask[31:16] = bus_wdata;
                    16'h10B4: m_lamp = bus_wdata[0];
                    16'h10D0: m_ra = bus_wdata;
                    16'h10D2: m_rb = bus_wdata;
                    default: ;
                endcase
            end
            m_stat  = m_pipe;
            m_pipe  = src_lvl;
            m_rdata = nrd;
            m_irq_n = nirq;
            m_tag   = ntag;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk(m_tag, {16'd0, bus_rdata}, {16'd0, m_rdata});
            chk("R4 irq_n", {31'd0, irq_n}, {31'd0, m_irq_n});
            chk("R7 backlight_on", {31'd0, backlight_on}, {31'd0, m_lamp});
            chk("R5 dev_rst_a", {16'd0, dev_rst_a}, {16'd0, m_ra});
            chk("R5 dev_rst_b", {16'd0, dev_rst_b}, {16'd0, m_rb});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [15:0] v;
        idle(4);
        chk("R1 irq_n in reset", {31'd0, irq_n}, 32'd1);
        chk("R1 rdata in reset", {16'd0, bus_rdata}, 32'd0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 backlight", {31'd0, backlight_on}, 32'd0);
        chk("R1 dev_rst_a", {16'd0, dev_rst_a}, 32'd0);
        bus_read(16'h0030, v); chk("R1 mask lo", {16'd0, v}, 32'hFFFF);
        bus_read(16'h0032, v); chk("R1 mask hi", {16'd0, v}, 32'hFFFF);

        // all sources high but every source still blocked
        src_lvl = 32'hFFFF_FFFF;
        idle(4);
        chk("R1 all masked irq_n", {31'd0, irq_n}, 32'd1);
        bus_read(16'h0020, v); chk("R2 status lo all", {16'd0, v}, 32'hFFFF);

        // Ethernet source only, top bit of the low status word
        src_lvl = 32'h0000_8000;
        idle(4);
        bus_read(16'h0020, v); chk("R2 eth status bit15", {16'd0, v}, 32'h8000);
        bus_read(16'h0022, v); chk("R2 status hi clear", {16'd0, v}, 32'h0000);
        chk("R3 masked irq_n", {31'd0, irq_n}, 32'd1);
        bus_write(16'h0030, 16'h7FFF);
        idle(1);
        chk("R4 eth unmasked irq_n", {31'd0, irq_n}, 32'd0);
        src_lvl = 32'd0;
        idle(4);
        chk("R4 source gone irq_n", {31'd0, irq_n}, 32'd1);

        // upper half source 16
        bus_write(16'h0032, 16'hFFFE);
        src_lvl = 32'h0001_0000;
        idle(4);
        chk("R4 src16 irq_n", {31'd0, irq_n}, 32'd0);
        bus_read(16'h0022, v); chk("R2 status hi bit0", {16'd0, v}, 32'h0001);
        bus_read(16'h0032, v); chk("R3 mask hi readback", {16'd0, v}, 32'hFFFE);
        bus_write(16'h0032, 16'hFFFF);
        idle(1);
        chk("R3 remask irq_n", {31'd0, irq_n}, 32'd1);

        // revision word, read-only
        bus_read(16'h1100, v); chk("R6 version", {16'd0, v}, 32'h3AC5);
        bus_write(16'h1100, 16'h0000);
        bus_read(16'h1100, v); chk("R6 version after write", {16'd0, v}, 32'h3AC5);

        // backlight
        bus_write(16'h10B4, 16'hFFFF);
        chk("R7 backlight on", {31'd0, backlight_on}, 32'd1);
        bus_read(16'h10B4, v); chk("R7 backlight readback", {16'd0, v}, 32'h0001);
        bus_write(16'h10B4, 16'hFFFE);
        chk("R7 backlight off", {31'd0, backlight_on}, 32'd0);

        // device resets
        bus_write(16'h10D0, 16'h0004);
        chk("R5 eth reset bit2", {16'd0, dev_rst_a}, 32'h0004);
        bus_write(16'h10D2, 16'hA5A5);
        bus_read(16'h10D2, v); chk("R5 reset b readback", {16'd0, v}, 32'hA5A5);
        bus_read(16'h10D0, v); chk("R5 reset a readback", {16'd0, v}, 32'h0004);

        // strap pins
        bus_read(16'h10E0, v); chk("R8 strap 101", {16'd0, v}, 32'h0500);
        clk_mode_strap = 3'b010;
        bus_read(16'h10E0, v); chk("R8 strap 010", {16'd0, v}, 32'h0200);

        // switch banks
        sw_level = 64'h1234_5678_9ABC_DEF0;
        bus_read(16'h0070, v); chk("R9 bank0", {16'd0, v}, 32'hDEF0);
        bus_read(16'h0072, v); chk("R9 bank1", {16'd0, v}, 32'h9ABC);
        bus_read(16'h0074, v); chk("R9 bank2", {16'd0, v}, 32'h5678);
        bus_read(16'h0076, v); chk("R9 bank3", {16'd0, v}, 32'h1234);
        bus_write(16'h0072, 16'h0000);
        bus_read(16'h0072, v); chk("R9 bank1 after write", {16'd0, v}, 32'h9ABC);

        // unmapped and odd addresses
        bus_read(16'h0024, v); chk("R10 unmapped 0024", {16'd0, v}, 32'h0000);
        bus_read(16'h1000, v); chk("R10 unmapped 1000", {16'd0, v}, 32'h0000);
        bus_read(16'h0031, v); chk("R10 odd 0031", {16'd0, v}, 32'h0000);
        bus_write(16'h0031, 16'h0000);
        bus_write(16'h10D1, 16'h0000);
        bus_read(16'h0030, v); chk("R10 mask lo untouched", {16'd0, v}, 32'h7FFF);
        bus_read(16'h10D0, v); chk("R10 reset a untouched", {16'd0, v}, 32'h0004);

        // read data hold
        bus_read(16'h1100, v);
        bus_addr = 16'h0030;
        idle(3);
        chk("R11 rdata held", {16'd0, bus_rdata}, 32'h3AC5);

        finish_run();
    end
endmodule